// File: doc/BRIEF.md
# Clock Mode and Stop-Recovery Controller

This controller chooses the core clock source of a chip and the operating mode of its clock generator. Software-style control inputs pick one of three sources: the frequency-locked loop output, the internal reference oscillator or the external reference. They also choose which reference feeds the loop, set a low-power bit that may power the loop down when it is bypassed, and set a two-bit output divider code. The controller turns these into enables for the loop and both references, a clock mux select, a divider tap select and a clock-valid flag. Seven modes result: off, loop engaged on either reference, and loop bypassed on either reference, each bypass mode in a normal and a low-power form.

The controller also sequences stop modes. The two deep stop kinds force every clock off, and only a reset brings the block back. The shallow stop kind powers the loop down and keeps each reference alive if its keep-in-stop bit is set. An interrupt wake from the shallow stop restores the mode that was active when stop was entered. When the external source is a crystal that had to restart, the output clock is held off until the oscillator has run a programmable number of cycles (4096 by default). A 9-bit oscillator trim register is kept here. Only the power-on reset loads it with its midpoint; the other resets leave it untouched.

All controls and status are plain level signals. There is no data stream, so the block has no valid/ready interface. Configuration inputs are captured on a write strobe.

Top module: `clkmode_ctrl`

## Requirements
- R1: With source code 00 (loop), 01 (internal) or 10 (external) on `src_sel` (11 acts as 00), `clk_sel` shows that code. `irc_en` is high when the internal source is selected or when the powered loop uses the internal reference (`ref_int`=1). `osc_en` is high when the external source is selected or when the powered loop uses the external reference (`ref_int`=0).
- R2: Both the power-on reset (`rst_n` low) and the synchronous `soft_rst` return the block to loop-engaged on the internal reference: `clk_sel`=00, `div_sel`=01 (divide-by-2), `fll_en`=1, `irc_en`=1, `osc_en`=0, `clk_valid`=1.
- R3: `div_sel` follows the captured divider code (00 /1, 01 /2, 10 /4, 11 /8). Changing the code alone changes neither `fll_en` nor `clk_sel`.
- R4: In the bypass modes `lp_mode`=1 drives `fll_en` low. `dbg_active`=1 keeps `fll_en` high regardless of `lp_mode`, and turns the loop back on if debug starts after the bit was set. When the loop output is selected, `lp_mode` has no effect.
- R5: A stop request with `stop_kind` 01 or 10 drives every enable and `clk_valid` low on the next edge. `wake_irq` is then ignored, and only a reset leaves this state.
- R6: A stop request with `stop_kind` 11 drives `fll_en` and `clk_valid` low, sets `irc_en` to the captured `irc_keep`, and sets `osc_en` to the captured `osc_keep`.
- R7: `wake_irq` during the shallow stop restores the previous mode. If the external source is selected, `osc_crystal`=1 and `osc_keep`=0, `clk_valid` stays low until `OSC_WAIT` pulses of `osc_tick` have been counted, and rises one cycle after `osc_ready`.
- R8: The wake wait is skipped, and `clk_valid` rises on the wake edge, when `osc_keep` was set or when `osc_crystal`=0.
- R9: `mode_stat` repeats `clk_sel` (00 loop, 01 internal, 10 external) one cycle later. `osc_ready` rises after `OSC_WAIT` ticks of an enabled crystal, or one cycle after enable for a plain clock, and clears whenever `osc_en` is low.
- R10: `trim_q` is 0x100 after the power-on reset, loads `trim_din` on `trim_we`, and keeps its value through `soft_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| soft_rst | input | 1 | Synchronous non-power-on reset |
| cfg_we | input | 1 | Captures the configuration inputs |
| src_sel | input | 2 | Clock source code |
| ref_int | input | 1 | Loop reference: 1 internal, 0 external |
| lp_mode | input | 1 | Low-power bit for the bypass modes |
| bdiv | input | 2 | Output divider code |
| irc_keep | input | 1 | Keep internal reference on in shallow stop |
| osc_keep | input | 1 | Keep external reference on in shallow stop |
| dbg_active | input | 1 | Debug link active, keeps loop powered |
| osc_crystal | input | 1 | External source is a crystal (1) or a plain clock (0) |
| osc_tick | input | 1 | One pulse per oscillator cycle, synchronised |
| stop_req | input | 1 | Stop entry strobe |
| stop_kind | input | 2 | 01/10 deep stop, 11 shallow stop |
| wake_irq | input | 1 | Interrupt wake strobe |
| trim_we | input | 1 | Trim register write |
| trim_din | input | 9 | Trim write data |
| fll_en | output | 1 | Loop power enable |
| irc_en | output | 1 | Internal reference enable |
| osc_en | output | 1 | External reference enable |
| clk_sel | output | 2 | Clock mux select |
| div_sel | output | 2 | Divider tap select |
| clk_valid | output | 1 | Output clock may be used |
| mode_stat | output | 2 | Clock mode status |
| osc_ready | output | 1 | Oscillator initialisation done |
| trim_q | output | 9 | Current trim value |

## Verification
The bench waits out the crystal restart and checks `clk_valid` one tick short of the count and again on the tick itself. A counter that is off by one would release the clock a cycle early or late, and a controller that reused a stale ready flag would skip the wait entirely. It also raises debug after the low-power bit is set, and sends interrupt wakes during deep stop. A design that latched the loop state, or that accepted wakes from deep stop, would leave the loop off or restart the clock. Trim retention across the soft reset, and its reload on power-on reset, separate the two reset kinds.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;
  localparam int SRC_W  = 2;
  localparam int DIV_W  = 2;
  localparam int TRIM_W = 9;
  localparam logic [TRIM_W-1:0] TRIM_POR = TRIM_W'(9'h100);

  localparam logic [SRC_W-1:0] CS_LOOP = 2'b00;
  localparam logic [SRC_W-1:0] CS_INT  = 2'b01;
  localparam logic [SRC_W-1:0] CS_EXT  = 2'b10;

  localparam logic [1:0] SK_NONE  = 2'b00;
  localparam logic [1:0] SK_DEEP1 = 2'b01;
  localparam logic [1:0] SK_DEEP2 = 2'b10;
  localparam logic [1:0] SK_SHALW = 2'b11;

  typedef enum logic [1:0] {
    ST_RUN   = 2'b00,
    ST_STOP3 = 2'b01,
    ST_WAKE  = 2'b10,
    ST_OFF   = 2'b11
  } seq_st_e;

  typedef struct packed {
    logic [SRC_W-1:0] src;
    logic             ref_int;
    logic             lp;
    logic [DIV_W-1:0] bdiv;
    logic             irc_keep;
    logic             osc_keep;
  } cfg_t;

  localparam cfg_t CFG_RST = '{src: CS_LOOP, ref_int: 1'b1, lp: 1'b0,
                               bdiv: 2'b01, irc_keep: 1'b0, osc_keep: 1'b0};

  function automatic logic [SRC_W-1:0] eff_src(input logic [SRC_W-1:0] s);
    return (s == 2'b11) ? CS_LOOP : s;
  endfunction
endpackage

// File: rtl/clkmode_cfg.sv
module clkmode_cfg
  import clkmode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              cfg_we,
  input  cfg_t              cfg_d,
  input  logic              trim_we,
  input  logic [TRIM_W-1:0] trim_din,
  output cfg_t              cfg_q,
  output logic [TRIM_W-1:0] trim_q
);
  // configuration returns to defaults on either reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfg_q <= CFG_RST;
    else if (soft_rst) cfg_q <= CFG_RST;
    else if (cfg_we)   cfg_q <= cfg_d;
  end

  // trim survives the soft reset; only power-on reset reloads the midpoint
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    trim_q <= TRIM_POR;
    else if (trim_we && !soft_rst) trim_q <= trim_din;
  end
endmodule

// File: rtl/clkmode_oscwait.sv
module clkmode_oscwait #(
  parameter int OSC_WAIT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic osc_en,
  input  logic osc_crystal,
  input  logic osc_tick,
  output logic osc_ready
);
  localparam int CNT_W = (OSC_WAIT > 2) ? $clog2(OSC_WAIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OSC_WAIT - 1);

  generate
    if (OSC_WAIT <= 1) begin : g_nowait
      // a single tick is enough: no counter needed
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  osc_ready <= 1'b0;
        else if (soft_rst || !osc_en) osc_ready <= 1'b0;
        else if (!osc_crystal || osc_tick) osc_ready <= 1'b1;
      end
    end else begin : g_count
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt       <= '0;
          osc_ready <= 1'b0;
        end else if (soft_rst || !osc_en) begin
          cnt       <= '0;
          osc_ready <= 1'b0;
        end else if (!osc_ready) begin
          if (!osc_crystal) begin
            osc_ready <= 1'b1;
          end else if (osc_tick) begin
            if (cnt == LAST) begin
              cnt       <= '0;
              osc_ready <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/clkmode_seq.sv
module clkmode_seq
  import clkmode_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             stop_req,
  input  logic [1:0]       stop_kind,
  input  logic             wake_irq,
  input  logic [SRC_W-1:0] src_eff,
  input  logic             osc_keep,
  input  logic             osc_crystal,
  input  logic             osc_ready,
  output seq_st_e          st
);
  logic need_wait;
  seq_st_e st_nx;

  // crystal restart is only needed if the oscillator was let go in stop
  assign need_wait = (src_eff == CS_EXT) && osc_crystal && !osc_keep;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_RUN: begin
        if (stop_req) begin
          if (stop_kind == SK_SHALW) st_nx = ST_STOP3;
          else if (stop_kind == SK_DEEP1 || stop_kind == SK_DEEP2) st_nx = ST_OFF;
        end
      end
      ST_STOP3: if (wake_irq) st_nx = need_wait ? ST_WAKE : ST_RUN;
      ST_WAKE:  if (osc_ready) st_nx = ST_RUN;
      ST_OFF:   st_nx = ST_OFF;
      default:  st_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        st <= ST_RUN;
    else if (soft_rst) st <= ST_RUN;
    else               st <= st_nx;
  end
endmodule

// File: rtl/clkmode_decode.sv
module clkmode_decode
  import clkmode_pkg::*;
(
  input  seq_st_e          st,
  input  logic [SRC_W-1:0] src_eff,
  input  logic             ref_int,
  input  logic             lp,
  input  logic             irc_keep,
  input  logic             osc_keep,
  input  logic             dbg_active,
  output logic             fll_en,
  output logic             irc_en,
  output logic             osc_en,
  output logic             clk_valid
);
  logic loop_on;

  // loop stays powered when engaged, when low power is off, or for debug
  assign loop_on = (src_eff == CS_LOOP) || !lp || dbg_active;

  always_comb begin
    fll_en    = 1'b0;
    irc_en    = 1'b0;
    osc_en    = 1'b0;
    clk_valid = 1'b0;
    unique case (st)
      ST_RUN, ST_WAKE: begin
        fll_en    = loop_on;
        irc_en    = (src_eff == CS_INT) || (loop_on && ref_int);
        osc_en    = (src_eff == CS_EXT) || (loop_on && !ref_int);
        clk_valid = (st == ST_RUN);
      end
      ST_STOP3: begin
        irc_en = irc_keep;
        osc_en = osc_keep;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
  import clkmode_pkg::*;
#(
  parameter int OSC_WAIT = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        cfg_we,
  input  logic [1:0]  src_sel,
  input  logic        ref_int,
  input  logic        lp_mode,
  input  logic [1:0]  bdiv,
  input  logic        irc_keep,
  input  logic        osc_keep,
  input  logic        dbg_active,
  input  logic        osc_crystal,
  input  logic        osc_tick,
  input  logic        stop_req,
  input  logic [1:0]  stop_kind,
  input  logic        wake_irq,
  input  logic        trim_we,
  input  logic [8:0]  trim_din,
  output logic        fll_en,
  output logic        irc_en,
  output logic        osc_en,
  output logic [1:0]  clk_sel,
  output logic [1:0]  div_sel,
  output logic        clk_valid,
  output logic [1:0]  mode_stat,
  output logic        osc_ready,
  output logic [8:0]  trim_q
);
  cfg_t             cfg_d, cfg_q;
  seq_st_e          st;
  logic [SRC_W-1:0] src_eff;

  assign cfg_d = '{src: src_sel, ref_int: ref_int, lp: lp_mode, bdiv: bdiv,
                   irc_keep: irc_keep, osc_keep: osc_keep};

  clkmode_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_we(cfg_we),
    .cfg_d(cfg_d), .trim_we(trim_we), .trim_din(trim_din),
    .cfg_q(cfg_q), .trim_q(trim_q)
  );

  assign src_eff = eff_src(cfg_q.src);
  assign clk_sel = src_eff;
  assign div_sel = cfg_q.bdiv;

  clkmode_oscwait #(.OSC_WAIT(OSC_WAIT)) u_oscwait (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .osc_en(osc_en),
    .osc_crystal(osc_crystal), .osc_tick(osc_tick), .osc_ready(osc_ready)
  );

  clkmode_seq u_seq (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stop_req(stop_req),
    .stop_kind(stop_kind), .wake_irq(wake_irq), .src_eff(src_eff),
    .osc_keep(cfg_q.osc_keep), .osc_crystal(osc_crystal),
    .osc_ready(osc_ready), .st(st)
  );

  clkmode_decode u_dec (
    .st(st), .src_eff(src_eff), .ref_int(cfg_q.ref_int), .lp(cfg_q.lp),
    .irc_keep(cfg_q.irc_keep), .osc_keep(cfg_q.osc_keep),
    .dbg_active(dbg_active), .fll_en(fll_en), .irc_en(irc_en),
    .osc_en(osc_en), .clk_valid(clk_valid)
  );

  // status reports the source only once the mux select has settled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mode_stat <= CS_LOOP;
    else if (soft_rst) mode_stat <= CS_LOOP;
    else               mode_stat <= clk_sel;
  end
endmodule

// File: rtl/clkmode_ctrl_chk.sv
module clkmode_ctrl_chk
  import clkmode_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       soft_rst,
  input logic       dbg_active,
  input seq_st_e    st,
  input logic       irc_keep_q,
  input logic       osc_keep_q,
  input logic       fll_en,
  input logic       irc_en,
  input logic       osc_en,
  input logic [1:0] clk_sel,
  input logic [1:0] div_sel,
  input logic       clk_valid,
  input logic [1:0] mode_stat,
  input logic       osc_ready,
  input logic [8:0] trim_q
);
  AST_RESET_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (clk_sel == CS_LOOP && div_sel == 2'b01 && fll_en && clk_valid)); // R2

  AST_DIV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && $stable(st) && $stable(clk_sel) && $stable(dbg_active)
     && !$stable(div_sel) && !$past(soft_rst) && !soft_rst) |-> $stable(fll_en) || !$stable(irc_en) || !$stable(osc_en)); // R3

  AST_DBG_KEEPS_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && dbg_active) |-> fll_en); // R4

  AST_OFF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OFF && !soft_rst) |=> (st == ST_OFF && !clk_valid && !fll_en && !irc_en && !osc_en)); // R5

  AST_SHALLOW_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STOP3) |-> (!fll_en && !clk_valid && irc_en == irc_keep_q && osc_en == osc_keep_q)); // R6

  AST_XTAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(clk_valid) && $past(st) == ST_WAKE) |-> osc_ready); // R7

  AST_MODE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(soft_rst) |-> mode_stat == $past(clk_sel)); // R9

  AST_TRIM_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> $stable(trim_q)); // R10
endmodule

bind clkmode_ctrl clkmode_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .dbg_active(dbg_active),
  .st(st), .irc_keep_q(cfg_q.irc_keep), .osc_keep_q(cfg_q.osc_keep),
  .fll_en(fll_en), .irc_en(irc_en), .osc_en(osc_en), .clk_sel(clk_sel),
  .div_sel(div_sel), .clk_valid(clk_valid), .mode_stat(mode_stat),
  .osc_ready(osc_ready), .trim_q(trim_q)
);

// File: tb/test_clkmode_ctrl.sv
module test_clkmode_ctrl;
  logic clk = 1'b0;
  logic rst_n, soft_rst, cfg_we, ref_int, lp_mode, irc_keep, osc_keep;
  logic dbg_active, osc_crystal, osc_tick, stop_req, wake_irq, trim_we;
  logic [1:0] src_sel, bdiv, stop_kind;
  logic [8:0] trim_din;
  logic fll_en, irc_en, osc_en, clk_valid, osc_ready;
  logic [1:0] clk_sel, div_sel, mode_stat;
  logic [8:0] trim_q;
  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  clkmode_ctrl i_clkmode_ctrl (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_we(cfg_we),
    .src_sel(src_sel), .ref_int(ref_int), .lp_mode(lp_mode), .bdiv(bdiv),
    .irc_keep(irc_keep), .osc_keep(osc_keep), .dbg_active(dbg_active),
    .osc_crystal(osc_crystal), .osc_tick(osc_tick), .stop_req(stop_req),
    .stop_kind(stop_kind), .wake_irq(wake_irq), .trim_we(trim_we),
    .trim_din(trim_din), .fll_en(fll_en), .irc_en(irc_en), .osc_en(osc_en),
    .clk_sel(clk_sel), .div_sel(div_sel), .clk_valid(clk_valid),
    .mode_stat(mode_stat), .osc_ready(osc_ready), .trim_q(trim_q)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // fll, irc, osc enables plus select in one go
  task automatic chk_en(input string req, input int f, input int i, input int o, input int s);
    chk(req, "fll_en", int'(fll_en), f);
    chk(req, "irc_en", int'(irc_en), i);
    chk(req, "osc_en", int'(osc_en), o);
    chk(req, "clk_sel", int'(clk_sel), s);
  endtask

  task automatic wcfg(input logic [1:0] s, input logic ri, input logic lp,
                      input logic [1:0] bd, input logic ik, input logic ok);
    @(negedge clk);
    src_sel = s; ref_int = ri; lp_mode = lp; bdiv = bd; irc_keep = ik; osc_keep = ok;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_stop(input logic [1:0] k);
    @(negedge clk); stop_req = 1'b1; stop_kind = k;
    @(negedge clk); stop_req = 1'b0; stop_kind = 2'b00;
  endtask

  task automatic do_wake();
    @(negedge clk); wake_irq = 1'b1;
    @(negedge clk); wake_irq = 1'b0;
  endtask

  task automatic do_soft();
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); osc_tick = 1'b1;
      @(negedge clk); osc_tick = 1'b0;
    end
  endtask

  task automatic t_reset();
    chk("R2", "fei enables", 0, 0);
    chk_en("R2", 1, 1, 0, 0);
    chk("R2", "div_sel", int'(div_sel), 1);
    chk("R2", "clk_valid", int'(clk_valid), 1);
    chk("R9", "mode_stat", int'(mode_stat), 0);
    chk("R9", "osc_ready", int'(osc_ready), 0);
    chk("R10", "trim por", int'(trim_q), 256);
  endtask

  task automatic t_modes();
    wcfg(2'b00, 1'b0, 1'b0, 2'b01, 1'b0, 1'b0); chk_en("R1 fee", 1, 0, 1, 0);
    wcfg(2'b01, 1'b1, 1'b0, 2'b01, 1'b0, 1'b0); chk_en("R1 fbi", 1, 1, 0, 1);
    wcfg(2'b10, 1'b0, 1'b0, 2'b01, 1'b0, 1'b0); chk_en("R1 fbe", 1, 0, 1, 2);
    wcfg(2'b10, 1'b1, 1'b0, 2'b01, 1'b0, 1'b0); chk_en("R1 fbe-intref", 1, 1, 1, 2);
    wcfg(2'b11, 1'b1, 1'b0, 2'b01, 1'b0, 1'b0); chk_en("R1 code11", 1, 1, 0, 0);
  endtask

  task automatic t_lp_dbg();
    wcfg(2'b01, 1'b1, 1'b1, 2'b01, 1'b0, 1'b0); chk_en("R4 fbilp", 0, 1, 0, 1);
    wcfg(2'b10, 1'b1, 1'b1, 2'b01, 1'b0, 1'b0); chk_en("R4 fbelp", 0, 0, 1, 2);
    @(negedge clk); dbg_active = 1'b1;
    #1 chk("R4", "dbg after lp", int'(fll_en), 1);
    wcfg(2'b01, 1'b1, 1'b1, 2'b01, 1'b0, 1'b0);
    chk("R4", "lp while dbg", int'(fll_en), 1);
    @(negedge clk); dbg_active = 1'b0;
    #1 chk("R4", "dbg drop", int'(fll_en), 0);
    wcfg(2'b00, 1'b1, 1'b1, 2'b01, 1'b0, 1'b0);
    chk("R4", "lp in fei", int'(fll_en), 1);
  endtask

  task automatic t_div();
    for (int d = 0; d < 4; d++) begin
      wcfg(2'b01, 1'b1, 1'b1, 2'(d), 1'b0, 1'b0);
      chk("R3", "div_sel", int'(div_sel), d);
      chk("R3", "fll kept", int'(fll_en), 0);
      chk("R3", "sel kept", int'(clk_sel), 1);
    end
  endtask

  task automatic t_status();
    wcfg(2'b00, 1'b1, 1'b0, 2'b01, 1'b0, 1'b0);
    @(negedge clk);
    chk("R9", "stat loop", int'(mode_stat), 0);
    wcfg(2'b10, 1'b0, 1'b0, 2'b01, 1'b0, 1'b0);
    chk("R9", "stat lags", int'(mode_stat), 0);
    @(negedge clk);
    chk("R9", "stat ext", int'(mode_stat), 2);
  endtask

  task automatic t_stop3();
    wcfg(2'b01, 1'b1, 1'b0, 2'b01, 1'b1, 1'b0);
    do_stop(2'b11);
    chk_en("R6 stop3", 0, 1, 0, 1);
    chk("R6", "valid in stop3", int'(clk_valid), 0);
    do_wake();
    chk_en("R7 fbi resume", 1, 1, 0, 1);
    chk("R7", "valid fbi", int'(clk_valid), 1);
  endtask

  task automatic t_wake_xtal();
    osc_crystal = 1'b1;
    wcfg(2'b10, 1'b1, 1'b1, 2'b01, 1'b0, 1'b0);
    chk("R9", "osc not ready", int'(osc_ready), 0);
    ticks(4096);
    chk("R9", "osc ready", int'(osc_ready), 1);
    do_stop(2'b11);
    chk("R6", "osc off in stop", int'(osc_en), 0);
    @(negedge clk);
    chk("R9", "ready clears", int'(osc_ready), 0);
    do_wake();
    chk("R7", "valid held", int'(clk_valid), 0);
    chk("R7", "osc restart", int'(osc_en), 1);
    ticks(4095);
    chk("R7", "valid one short", int'(clk_valid), 0);
    ticks(1);
    chk("R7", "ready at count", int'(osc_ready), 1);
    chk("R7", "valid still low", int'(clk_valid), 0);
    @(negedge clk);
    chk("R7", "valid after wait", int'(clk_valid), 1);
    chk("R7", "sel ext", int'(clk_sel), 2);
  endtask

  task automatic t_wake_skip();
    wcfg(2'b10, 1'b1, 1'b1, 2'b01, 1'b0, 1'b1);
    do_stop(2'b11);
    chk("R6", "osc kept", int'(osc_en), 1);
    do_wake();
    chk("R8", "keep skips wait", int'(clk_valid), 1);
    osc_crystal = 1'b0;
    wcfg(2'b10, 1'b1, 1'b1, 2'b01, 1'b0, 1'b0);
    do_stop(2'b11);
    @(negedge clk);
    do_wake();
    chk("R8", "plain clock skips", int'(clk_valid), 1);
    @(negedge clk);
    chk("R9", "plain ready", int'(osc_ready), 1);
  endtask

  task automatic t_deep();
    @(negedge clk); trim_we = 1'b1; trim_din = 9'h0A5;
    @(negedge clk); trim_we = 1'b0;
    chk("R10", "trim write", int'(trim_q), 165);
    wcfg(2'b01, 1'b1, 1'b0, 2'b11, 1'b1, 1'b1);
    do_stop(2'b01);
    chk_en("R5 deep1", 0, 0, 0, 1);
    chk("R5", "valid deep1", int'(clk_valid), 0);
    do_wake();
    chk("R5", "irq ignored", int'(clk_valid), 0);
    chk("R5", "irq ignored irc", int'(irc_en), 0);
    do_soft();
    chk_en("R2 soft", 1, 1, 0, 0);
    chk("R2", "soft div", int'(div_sel), 1);
    chk("R2", "soft valid", int'(clk_valid), 1);
    chk("R10", "trim kept", int'(trim_q), 165);
    do_stop(2'b10);
    chk("R5", "deep2 valid", int'(clk_valid), 0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "trim por again", int'(trim_q), 256);
    chk("R2", "por valid", int'(clk_valid), 1);
  endtask

  initial begin
    rst_n = 1'b0; soft_rst = 1'b0; cfg_we = 1'b0; src_sel = 2'b00; ref_int = 1'b1;
    lp_mode = 1'b0; bdiv = 2'b01; irc_keep = 1'b0; osc_keep = 1'b0;
    dbg_active = 1'b0; osc_crystal = 1'b0; osc_tick = 1'b0; stop_req = 1'b0;
    stop_kind = 2'b00; wake_irq = 1'b0; trim_we = 1'b0; trim_din = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_modes();
    t_lp_dbg();
    t_div();
    t_status();
    t_stop3();
    t_wake_xtal();
    t_wake_skip();
    t_deep();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule